// File: doc/BRIEF.md
# Output Kill Watchdog with Timed Bypass

This block is a latching safety guard between the samples an application computes for its output converters and the converter interface itself. When its health input reports a fault, every channel it owns is driven to zero, and it stays that way until an operator issues a reset while the health input reads good. A controlled, time-limited bypass lets the outputs run while the health input is ignored. An operator panic level overrides everything else.

All state changes happen on code cycles, which are clock cycles with the `tick` input high. The block leaves reset in the tripped state, whatever the health input says. A bypass lasts a programmable number of seconds, and `TICKS_PER_SEC` sets how many ticks make one second. A bypass ends by itself and returns to monitoring without a reset. It cannot be extended by asking for it again.

Top module: `outkill_wdog`

## Requirements
- R1: After reset the block reports tripped (status 0), drives all sample outputs to zero, shows 0 seconds of bypass left, and holds the reset indication low.
- R2: The status code is 0 = tripped, 1 = monitoring, 2 = bypassed. In states 1 and 2 every channel output equals its input. In state 0 every channel output is zero.
- R3: In monitoring, a tick with health 0 (and no panic, reset or accepted bypass request) moves the block to tripped. Once tripped, a healthy input on its own does not clear the trip.
- R4: A reset request taken on a tick (panic low) moves the block to monitoring if health is 1 and to tripped if health is 0, from any state, and cancels any bypass. The reset indication is high from that tick until the next tick, which is exactly one code cycle.
- R5: A bypass request on a tick, with panic low, no reset request, a nonzero duration and the block not already bypassed, enters bypass and loads the duration into the seconds-left output. A zero duration leaves the state unchanged.
- R6: While bypassed the health input is ignored, and further bypass requests neither restart nor extend the timer.
- R7: The seconds-left output drops by one every `TICKS_PER_SEC` ticks spent in bypass. After duration × `TICKS_PER_SEC` ticks the block returns to monitoring with 0 seconds left. Outside bypass the output reads 0.
- R8: A tick with panic high forces the tripped state, clears the bypass timer and takes precedence over reset and bypass requests, so no reset indication is produced. Releasing panic leaves the block tripped, not bypassed.
- R9: Clock cycles without `tick` change neither the state, the timer nor the reset indication, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Code-cycle enable |
| health | input | 1 | 1 = healthy, 0 = fault |
| byp_secs | input | SECW | Bypass duration in seconds, sampled on bypass entry |
| req_reset | input | 1 | Operator reset request (single-cycle pulse) |
| req_bypass | input | 1 | Operator bypass request (single-cycle pulse) |
| panic | input | 1 | Operator panic level |
| samp_in | input | NCH*DW | Application channel samples, channel 0 in the low bits |
| samp_out | output | NCH*DW | Gated channel samples |
| status | output | 2 | 0 tripped, 1 monitoring, 2 bypassed |
| rst_pulse | output | 1 | High for one code cycle after an accepted reset |
| byp_left | output | SECW | Whole seconds left on the bypass timer |

## Verification
Several rules are checked by the assertions on every cycle. Panic always lands in tripped. Non-tick cycles hold the state. A trip stays latched without a reset or a bypass. The timer never counts up while bypassed, and a bypass request cannot lift it. Zero outputs line up with the tripped status, and the seconds-left value lines up with the bypass status. Only the bench scenarios can show the exact countdown length for each duration, the reset indication lasting until the next tick, the outcome for every combination of requests from each state, and that releasing panic leaves the block tripped.

// File: rtl/outkill_pkg.sv
package outkill_pkg;
    typedef enum logic [1:0] {
        ST_TRIP = 2'd0,
        ST_MON  = 2'd1,
        ST_BYP  = 2'd2
    } okw_state_e;

    typedef struct packed {
        okw_state_e st;
        logic       rpulse;
    } okw_ctrl_s;
endpackage

// File: rtl/okw_timer.sv
module okw_timer #(
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECW          = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            load,
    input  logic            kill,
    input  logic            run,
    input  logic [SECW-1:0] dur,
    output logic [SECW-1:0] left,
    output logic            expire
);
    localparam int SUBW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [SUBW-1:0] SUB_LAST = SUBW'(TICKS_PER_SEC - 1);

    typedef struct packed {
        logic [SECW-1:0] secs;
        logic [SUBW-1:0] sub;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && (tmr_q.sub == SUB_LAST) && (tmr_q.secs == SECW'(1));
        if (tick) begin
            if (kill) begin
                tmr_d.secs = '0;
                tmr_d.sub  = '0;
            end else if (load) begin
                tmr_d.secs = dur;
                tmr_d.sub  = '0;
            end else if (run) begin
                if (tmr_q.sub == SUB_LAST) begin
                    tmr_d.sub  = '0;
                    tmr_d.secs = tmr_q.secs - SECW'(1);
                end else begin
                    tmr_d.sub = tmr_q.sub + SUBW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign left = tmr_q.secs;

    // R7: a running countdown never goes up
    assert_count_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !kill && !load) |=> (left <= $past(left)));
    // R6: a repeated request while running cannot lift the timer
    assert_no_extend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (left <= $past(left)));
endmodule

// File: rtl/okw_ctrl.sv
module okw_ctrl
    import outkill_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       health,
    input  logic       req_reset,
    input  logic       req_bypass,
    input  logic       panic,
    input  logic       dur_nz,
    input  logic       expire,
    output okw_state_e state,
    output logic       rpulse,
    output logic       load,
    output logic       kill
);
    okw_ctrl_s ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        load  = 1'b0;
        kill  = 1'b0;
        if (tick) begin
            ctl_d.rpulse = 1'b0;
            if (panic) begin
                ctl_d.st = ST_TRIP;
                kill     = 1'b1;
            end else if (req_reset) begin
                ctl_d.rpulse = 1'b1;
                ctl_d.st     = health ? ST_MON : ST_TRIP;
                kill         = 1'b1;
            end else if (req_bypass && dur_nz && ctl_q.st != ST_BYP) begin
                ctl_d.st = ST_BYP;
                load     = 1'b1;
            end else begin
                unique case (ctl_q.st)
                    ST_MON:  if (!health) ctl_d.st = ST_TRIP;
                    ST_BYP:  if (expire)  ctl_d.st = ST_MON;
                    default: ctl_d.st = ctl_q.st;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.st     <= ST_TRIP;
            ctl_q.rpulse <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign state  = ctl_q.st;
    assign rpulse = ctl_q.rpulse;

    // R8: panic on a tick always trips
    assert_panic_trips_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && panic) |=> (state == ST_TRIP && !rpulse));
    // R9: non-tick cycles hold everything
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(state) && $stable(rpulse)));
    // R3: a trip stays latched without reset or accepted bypass
    assert_trip_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TRIP && !req_reset && !(req_bypass && dur_nz && !panic))
        |=> (state == ST_TRIP));
endmodule

// File: rtl/okw_gate.sv
module okw_gate #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input  logic              pass,
    input  logic [NCH*DW-1:0] din,
    output logic [NCH*DW-1:0] dout
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign dout[c*DW +: DW] = pass ? din[c*DW +: DW] : '0;
    end
endmodule

// File: rtl/outkill_wdog.sv
module outkill_wdog
    import outkill_pkg::*;
#(
    parameter int NCH           = 4,
    parameter int DW            = 16,
    parameter int TICKS_PER_SEC = 1000,
    parameter int SECW          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              health,
    input  logic [SECW-1:0]   byp_secs,
    input  logic              req_reset,
    input  logic              req_bypass,
    input  logic              panic,
    input  logic [NCH*DW-1:0] samp_in,
    output logic [NCH*DW-1:0] samp_out,
    output logic [1:0]        status,
    output logic              rst_pulse,
    output logic [SECW-1:0]   byp_left
);
    okw_state_e state;
    logic load, kill, expire, rpulse;

    okw_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .health(health),
        .req_reset(req_reset), .req_bypass(req_bypass), .panic(panic),
        .dur_nz(byp_secs != '0), .expire(expire),
        .state(state), .rpulse(rpulse), .load(load), .kill(kill)
    );

    okw_timer #(.TICKS_PER_SEC(TICKS_PER_SEC), .SECW(SECW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load), .kill(kill),
        .run(state == ST_BYP), .dur(byp_secs), .left(byp_left), .expire(expire)
    );

    okw_gate #(.NCH(NCH), .DW(DW)) u_gate (
        .pass(state != ST_TRIP), .din(samp_in), .dout(samp_out)
    );

    assign status    = state;
    assign rst_pulse = rpulse;

    // R2: tripped status always comes with zero outputs
    assert_trip_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'd0) |-> (samp_out == '0));
    // R7: seconds-left matches the bypass status
    assert_left_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 2'd2) == (byp_left != '0)));
    // R1: leaving reset starts tripped
    assert_start_trip_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (status == 2'd0 && !rst_pulse));
    // R4: reset indication only follows an accepted reset request
    assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> $past(tick && req_reset && !panic));
endmodule

// File: tb/outkill_wdog_test.sv
module outkill_wdog_test;
    localparam int NCH = 2, DW = 8, TPS = 3, SECW = 4;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, health = 1'b0;
    logic [SECW-1:0] byp_secs = '0;
    logic req_reset = 1'b0, req_bypass = 1'b0, panic = 1'b0;
    logic [NCH*DW-1:0] samp_in = 16'hA53C;
    logic [NCH*DW-1:0] samp_out;
    logic [1:0] status;
    logic rst_pulse;
    logic [SECW-1:0] byp_left;
    int total = 0, bad = 0;

    outkill_wdog #(.NCH(NCH), .DW(DW), .TICKS_PER_SEC(TPS), .SECW(SECW)) uut (.*);

    always #2.5 clk = ~clk;

    task automatic check(string rq, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic step(logic h, logic r, logic b, logic p, int dur);
        @(negedge clk);
        health = h; req_reset = r; req_bypass = b; panic = p;
        byp_secs = SECW'(dur); tick = 1'b1;
        @(negedge clk);
        tick = 1'b0; req_reset = 1'b0; req_bypass = 1'b0;
    endtask

    task automatic idle(int n, logic h, logic r, logic b);
        @(negedge clk);
        health = h; req_reset = r; req_bypass = b; tick = 1'b0;
        repeat (n) @(negedge clk);
        req_reset = 1'b0; req_bypass = 1'b0;
    endtask

    task automatic go_trip(); step(1, 0, 0, 1, 0); step(1, 0, 0, 0, 0); endtask
    task automatic go_mon();  go_trip(); step(1, 1, 0, 0, 0); endtask
    task automatic go_byp();  go_mon();  step(1, 0, 1, 0, 2); endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check("R1 status", status, 0);
        check("R1 samp_out", samp_out, 0);
        check("R1 byp_left", byp_left, 0);
        check("R1 rst_pulse", rst_pulse, 0);
        // R3: healthy alone does not clear
        step(1, 0, 0, 0, 0);
        check("R3 latched", status, 0);
        // R4: reset while unhealthy stays tripped, still pulses
        step(0, 1, 0, 0, 0);
        check("R4 reset unhealthy", status, 0);
        check("R4 pulse", rst_pulse, 1);
        step(0, 0, 0, 0, 0);
        check("R4 pulse one cycle", rst_pulse, 0);
        // R4/R2: healthy reset
        step(1, 1, 0, 0, 0);
        check("R4 to monitor", status, 1);
        check("R2 pass", samp_out, samp_in);
        idle(3, 0, 0, 0);
        check("R4 pulse held to next tick", rst_pulse, 1);
        // R9: no-tick inputs ignored
        check("R9 idle health0", status, 1);
        idle(2, 1, 1, 1);
        check("R9 idle bypass", status, 1);
        check("R9 idle bypass left", byp_left, 0);
        step(1, 0, 0, 0, 0);
        check("R4 pulse drop", rst_pulse, 0);
        // R3
        step(0, 0, 0, 0, 0);
        check("R3 trip", status, 0);
        check("R2 zero", samp_out, 0);
        step(1, 0, 0, 0, 0);
        check("R3 stays", status, 0);
        // R5: zero duration ignored
        step(1, 1, 0, 0, 0);
        step(1, 0, 1, 0, 0);
        check("R5 zero dur", status, 1);
        check("R5 zero dur left", byp_left, 0);
        // R6/R7: countdown sweep
        for (int d = 1; d <= 3; d++) begin
            step(1, 1, 0, 0, 0);
            step(1, 0, 1, 0, d);
            check("R5 enter", status, 2);
            check("R5 load", byp_left, d);
            check("R2 pass byp", samp_out, samp_in);
            for (int k = 1; k <= d * TPS; k++) begin
                step(0, 0, k % 2, 0, 7);
                if (k < d * TPS) begin
                    check("R6 health ignored", status, 2);
                    check("R7 left", byp_left, d - k / TPS);
                end else begin
                    check("R7 expire", status, 1);
                    check("R7 left zero", byp_left, 0);
                end
            end
        end
        // R8
        go_byp();
        step(1, 0, 0, 1, 0);
        check("R8 panic trips", status, 0);
        check("R8 timer cleared", byp_left, 0);
        step(1, 1, 0, 1, 0);
        check("R8 reset blocked", status, 0);
        check("R8 no pulse", rst_pulse, 0);
        step(1, 0, 1, 1, 3);
        check("R8 bypass blocked", status, 0);
        step(1, 0, 0, 0, 3);
        check("R8 release stays trip", status, 0);
        check("R8 release left", byp_left, 0);
        // near-exhaustive sweep of states and request combos
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 16; v++) begin
                logic h, r, b, p;
                int es, el;
                string rq;
                h = v[0]; r = v[1]; b = v[2]; p = v[3];
                if (s == 0) go_trip(); else if (s == 1) go_mon(); else go_byp();
                step(h, r, b, p, 2);
                if (p) begin es = 0; rq = "R8 sweep"; end
                else if (r) begin es = h ? 1 : 0; rq = "R4 sweep"; end
                else if (b && s != 2) begin es = 2; rq = "R5 sweep"; end
                else if (s == 1 && !h) begin es = 0; rq = "R3 sweep"; end
                else begin es = s; rq = (s == 2) ? "R6 sweep" : "R3 sweep"; end
                el = (es == 2) ? 2 : 0;
                check(rq, status, es);
                check({rq, " left"}, byp_left, el);
                check("R4 sweep pulse", rst_pulse, (r && !p) ? 1 : 0);
                check("R2 sweep out", samp_out, (es != 0) ? samp_in : 0);
            end
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule